// File: doc/BRIEF.md
# CAN Fault-Confinement Error Counters

This block keeps the transmit and receive error counters of a CAN controller and derives its fault-confinement state from them: error-active, error-passive or bus-off. The protocol engine reports one-cycle strobes for transmit errors, successful transmissions, receive errors and successful receptions. The block turns these strobes into counter updates and raises bus-off when the transmit count would pass 255.

Once the block is in bus-off, it ignores the protocol strobes. It watches the sampled nominal bit stream instead, and reuses the receive counter to count completed runs of eleven consecutive recessive bits. When the 128th such run completes, the block returns to error-active with both counters at zero. Three conditions clear everything and hold it cleared while they last: a soft-reset strobe, a low controller-enable level, or snoop mode. The counters can be read as one 32-bit word through a register port that ignores writes.

Top module: `can_err_counters`

## Requirements
- R1: After the synchronous active-high reset, `tec` and `rec` are 0 and `err_state` is 2'd0 (error-active).
- R2: Outside bus-off, a `tx_err` strobe adds 8 to `tec`. Otherwise a `tx_ok` strobe subtracts 1 from `tec`, never below 0. `tx_err` wins when both strobes are high in the same cycle.
- R3: Outside bus-off, an `rx_err` strobe adds 1 to `rec`, saturating at 255. Otherwise an `rx_ok` strobe subtracts 1 from `rec`, never below 0.
- R4: `err_state` is 2'd1 (error-passive) when the block is not in bus-off and either counter is 128 or more. It is 2'd0 when the block is not in bus-off and both counters are below 128.
- R5: A `tx_err` strobe that would push `tec` above 255 (that is, `tec` is 248 or more) moves the block to bus-off (`err_state` 2'd2) on the next cycle, with both counters cleared.
- R6: In bus-off, `tec` stays 0 and the protocol strobes have no effect. `rec` rises by exactly 1 when a run of eleven consecutive `bit_valid` samples with `bit_rec`=1 completes. A sample with `bit_rec`=0 restarts the run, and each completed run restarts the run from zero.
- R7: The bit that completes the 128th run returns the block to error-active on the next cycle, with `rec` back at 0.
- R8: A `soft_rst` strobe clears both counters on the next cycle and ends bus-off.
- R9: While `ctrl_en` is 0, both counters are held at 0 and the state is error-active.
- R10: While `snoop` is 1, both counters are held at 0 and `reg_rdata` reads 0.
- R11: `reg_rdata` carries `tec` in bits [7:0] and `rec` in bits [15:8], and bits [31:16] read 0. Asserting `reg_wr` with any `reg_wdata` leaves both counters unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err | input | 1 | Transmit error strobe |
| tx_ok | input | 1 | Successful transmission strobe |
| rx_err | input | 1 | Receive error strobe |
| rx_ok | input | 1 | Successful reception strobe |
| bit_valid | input | 1 | A nominal bit sample is present this cycle |
| bit_rec | input | 1 | Sampled bit level, 1 = recessive |
| soft_rst | input | 1 | Soft-reset strobe |
| ctrl_en | input | 1 | Controller enable level |
| snoop | input | 1 | Snoop (listen-only) mode level |
| reg_wr | input | 1 | Write strobe to the error-count register |
| reg_wdata | input | 32 | Write data (ignored) |
| reg_rdata | output | 32 | Error-count register word |
| tec | output | 8 | Transmit error counter |
| rec | output | 8 | Receive error counter / recovery run count |
| err_state | output | 2 | 0 active, 1 passive, 2 bus-off |

## Verification
The bound checker watches several rules on every cycle. It checks that `tec` is zero throughout bus-off and that `rec` moves by at most one step there. It checks the step size of a transmit error, the clears after soft reset and disable, the zero read under snoop, the zero upper register bits, and that error-passive always has a counter at 128 or more. Other properties need long, specific input histories, and only the bench scenarios can show them. These are the exact bus-off threshold, a run broken after ten recessive bits, the exit on the 128th run, saturation at 255, and writes that change nothing. The bench drives these against a cycle model built from the requirements.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

    parameter int CNT_W         = 8;
    parameter int TX_ERR_STEP   = 8;
    parameter int PASSIVE_LIM   = 128;
    parameter int RUN_LEN       = 11;
    parameter int RECOVERY_RUNS = 128;
    parameter int REG_W         = 32;

    typedef enum logic [1:0] {
        ERR_ACTIVE  = 2'd0,
        ERR_PASSIVE = 2'd1,
        ERR_BUSOFF  = 2'd2
    } err_state_e;

    typedef struct packed {
        logic tx_err;
        logic tx_ok;
        logic rx_err;
        logic rx_ok;
    } proto_evt_t;

    function automatic err_state_e classify(input logic busoff,
                                            input logic [CNT_W-1:0] t,
                                            input logic [CNT_W-1:0] r);
        if (busoff)
            return ERR_BUSOFF;
        else if (int'(t) >= PASSIVE_LIM || int'(r) >= PASSIVE_LIM)
            return ERR_PASSIVE;
        else
            return ERR_ACTIVE;
    endfunction

    function automatic logic [CNT_W-1:0] dec_floor(input logic [CNT_W-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

endpackage

// File: rtl/can_tx_err_ctr.sv
module can_tx_err_ctr
    import can_err_pkg::*;
#(
    parameter int W    = CNT_W,
    parameter int STEP = TX_ERR_STEP
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         freeze_zero,
    input  proto_evt_t   evt,
    output logic [W-1:0] cnt,
    output logic         would_ovf
);
    logic [W:0] sum;

    assign sum       = {1'b0, cnt} + (W+1)'(STEP);
    assign would_ovf = sum[W];

    always_ff @(posedge clk) begin
        if (rst || clr || freeze_zero)
            cnt <= '0;
        else if (evt.tx_err)
            cnt <= would_ovf ? '0 : sum[W-1:0];
        else if (evt.tx_ok)
            cnt <= dec_floor(cnt);
    end
endmodule

// File: rtl/can_rx_err_ctr.sv
module can_rx_err_ctr
    import can_err_pkg::*;
#(
    parameter int W    = CNT_W,
    parameter int RUNS = RECOVERY_RUNS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         recovering,
    input  logic         run_done,
    input  proto_evt_t   evt,
    output logic [W-1:0] cnt,
    output logic         last_run
);
    localparam logic [W-1:0] LAST_IDX = W'(RUNS - 1);
    localparam logic [W-1:0] CNT_MAX  = {W{1'b1}};

    assign last_run = recovering && run_done && (cnt == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (recovering) begin
            if (run_done)
                cnt <= last_run ? '0 : cnt + 1'b1;
        end else if (evt.rx_err) begin
            if (cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end else if (evt.rx_ok) begin
            cnt <= dec_floor(cnt);
        end
    end
endmodule

// File: rtl/can_recessive_run.sv
module can_recessive_run
    import can_err_pkg::*;
#(
    parameter int LEN = RUN_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic bit_valid,
    input  logic bit_rec,
    output logic done
);
    localparam int RW = $clog2(LEN + 1);
    localparam logic [RW-1:0] LAST = RW'(LEN - 1);

    logic [RW-1:0] run;

    assign done = en && bit_valid && bit_rec && (run == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en)
            run <= '0;
        else if (bit_valid) begin
            if (!bit_rec || done)
                run <= '0;
            else
                run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/can_err_counters.sv
module can_err_counters
    import can_err_pkg::*;
#(
    parameter int W    = CNT_W,
    parameter int DW   = REG_W,
    parameter int STEP = TX_ERR_STEP,
    parameter int LEN  = RUN_LEN,
    parameter int RUNS = RECOVERY_RUNS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_err,
    input  logic          tx_ok,
    input  logic          rx_err,
    input  logic          rx_ok,
    input  logic          bit_valid,
    input  logic          bit_rec,
    input  logic          soft_rst,
    input  logic          ctrl_en,
    input  logic          snoop,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [W-1:0]  tec,
    output logic [W-1:0]  rec,
    output logic [1:0]    err_state
);
    proto_evt_t evt;
    logic       gate_clear;
    logic       busoff;
    logic       enter_bo;
    logic       tx_ovf;
    logic       run_done;
    logic       last_run;
    logic       recovering;
    logic       unused_wr;

    assign evt        = '{tx_err: tx_err, tx_ok: tx_ok, rx_err: rx_err, rx_ok: rx_ok};
    assign gate_clear = soft_rst || !ctrl_en || snoop;
    assign recovering = busoff && !gate_clear;
    assign enter_bo   = !busoff && tx_err && tx_ovf;
    assign unused_wr  = ^{reg_wr, reg_wdata};

    can_tx_err_ctr #(.W(W), .STEP(STEP)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .clr        (gate_clear),
        .freeze_zero(busoff),
        .evt        (evt),
        .cnt        (tec),
        .would_ovf  (tx_ovf)
    );

    can_rx_err_ctr #(.W(W), .RUNS(RUNS)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .clr       (gate_clear || enter_bo),
        .recovering(recovering),
        .run_done  (run_done),
        .evt       (evt),
        .cnt       (rec),
        .last_run  (last_run)
    );

    can_recessive_run #(.LEN(LEN)) u_run (
        .clk      (clk),
        .rst      (rst),
        .en       (recovering),
        .bit_valid(bit_valid),
        .bit_rec  (bit_rec),
        .done     (run_done)
    );

    always_ff @(posedge clk) begin
        if (rst || gate_clear)
            busoff <= 1'b0;
        else if (enter_bo)
            busoff <= 1'b1;
        else if (last_run)
            busoff <= 1'b0;
    end

    assign err_state = classify(busoff, tec, rec);

    generate
        if (DW > 2*W) begin : g_pad
            assign reg_rdata = snoop ? '0 : {{(DW-2*W){1'b0}}, rec, tec};
        end else begin : g_nopad
            assign reg_rdata = snoop ? '0 : DW'({rec, tec});
        end
    endgenerate
endmodule

// File: rtl/can_err_checker.sv
module can_err_checker
    import can_err_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        tx_err,
    input logic        soft_rst,
    input logic        ctrl_en,
    input logic        snoop,
    input logic [31:0] reg_rdata,
    input logic [7:0]  tec,
    input logic [7:0]  rec,
    input logic [1:0]  err_state
);
    assert_tec_zero_busoff_R6: assert property (@(posedge clk) disable iff (rst)
        (err_state == ERR_BUSOFF) |-> (tec == 8'd0));

    assert_rec_step_busoff_R6: assert property (@(posedge clk) disable iff (rst)
        (err_state == ERR_BUSOFF && ctrl_en && !snoop && !soft_rst) |=>
        (rec == $past(rec) || rec == $past(rec) + 8'd1 || rec == 8'd0));

    assert_tx_step_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_en && !snoop && !soft_rst && err_state != ERR_BUSOFF && tx_err && tec < 8'd248)
        |=> (tec == $past(tec) + 8'd8));

    assert_passive_cause_R4: assert property (@(posedge clk) disable iff (rst)
        (err_state == ERR_PASSIVE) |-> (tec >= 8'd128 || rec >= 8'd128));

    assert_busoff_entry_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(err_state == ERR_BUSOFF) |-> (tec == 8'd0 && rec == 8'd0));

    assert_softrst_clear_R8: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (tec == 8'd0 && rec == 8'd0 && err_state == ERR_ACTIVE));

    assert_disable_clear_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_en |=> (tec == 8'd0 && rec == 8'd0));

    assert_snoop_read_R10: assert property (@(posedge clk) disable iff (rst)
        snoop |-> (reg_rdata == 32'd0));

    assert_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[31:16] == 16'd0);
endmodule

bind can_err_counters can_err_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_err   (tx_err),
    .soft_rst (soft_rst),
    .ctrl_en  (ctrl_en),
    .snoop    (snoop),
    .reg_rdata(reg_rdata),
    .tec      (tec),
    .rec      (rec),
    .err_state(err_state)
);

// File: tb/sim_can_err_counters.sv
`timescale 1ns/1ps
module sim_can_err_counters;
    logic        clk = 1'b0;
    logic        rst;
    logic        tx_err, tx_ok, rx_err, rx_ok;
    logic        bit_valid, bit_rec;
    logic        soft_rst, ctrl_en, snoop, reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [7:0]  tec, rec;
    logic [1:0]  err_state;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int m_tec = 0, m_rec = 0, m_run = 0;
    bit m_bo = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    can_err_counters u0 (
        .clk(clk), .rst(rst), .tx_err(tx_err), .tx_ok(tx_ok),
        .rx_err(rx_err), .rx_ok(rx_ok), .bit_valid(bit_valid), .bit_rec(bit_rec),
        .soft_rst(soft_rst), .ctrl_en(ctrl_en), .snoop(snoop), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tec(tec), .rec(rec),
        .err_state(err_state)
    );

    function automatic int exp_state();
        if (m_bo) return 2;
        if (m_tec >= 128 || m_rec >= 128) return 1;
        return 0;
    endfunction

    function automatic int exp_rdata();
        if (snoop) return 0;
        return (m_rec << 8) | m_tec;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic model_step();
        if (soft_rst || !ctrl_en || snoop) begin
            m_tec = 0; m_rec = 0; m_run = 0; m_bo = 1'b0;
        end else if (m_bo) begin
            if (bit_valid) begin
                if (!bit_rec) m_run = 0;
                else if (m_run == 10) begin
                    m_run = 0;
                    if (m_rec == 127) begin m_bo = 1'b0; m_rec = 0; end
                    else m_rec++;
                end else m_run++;
            end
        end else begin
            if (tx_err) begin
                if (m_tec + 8 > 255) begin
                    m_bo = 1'b1; m_tec = 0; m_rec = 0; m_run = 0;
                end else m_tec += 8;
            end else if (tx_ok && m_tec > 0) m_tec--;
            if (!m_bo) begin
                if (rx_err) begin if (m_rec < 255) m_rec++; end
                else if (rx_ok && m_rec > 0) m_rec--;
            end
        end
    endtask

    task automatic idle_in();
        tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0;
        bit_valid = 0; bit_rec = 1; soft_rst = 0; reg_wr = 0; reg_wdata = '0;
    endtask

    // inputs are set before the call (after a negedge); the model steps at the edge
    task automatic cyc(input string tt, input string tr, input string ts, input string td);
        @(posedge clk);
        model_step();
        #1;
        check(tt, int'(tec), m_tec);
        check(tr, int'(rec), m_rec);
        check(ts, int'(err_state), exp_state());
        check(td, int'(reg_rdata), exp_rdata());
        @(negedge clk);
        idle_in();
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 150000);
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        idle_in(); ctrl_en = 1; snoop = 0; rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1: reset values
        check("R1 tec", int'(tec), 0);
        check("R1 rec", int'(rec), 0);
        check("R1 state", int'(err_state), 0);

        // random normal traffic (R2, R3, R4, R11)
        for (int i = 0; i < 3000; i++) begin
            tx_err = ($urandom % 100) < 6;
            tx_ok  = ($urandom % 100) < 40;
            rx_err = ($urandom % 100) < 35;
            rx_ok  = ($urandom % 100) < 25;
            soft_rst = ($urandom % 1000) < 3;
            bit_valid = $urandom % 2; bit_rec = ($urandom % 100) < 95;
            reg_wr = $urandom % 2; reg_wdata = $urandom;
            cyc("R2 tec", "R3 rec", "R4 state", "R11 rdata");
        end

        // R3: saturation at 255
        soft_rst = 1; cyc("R8 tec", "R8 rec", "R8 state", "R8 rdata");
        for (int i = 0; i < 260; i++) begin
            rx_err = 1; cyc("R2 tec", "R3 rec", "R4 state", "R11 rdata");
        end
        check("R3 saturate", int'(rec), 255);
        check("R4 passive", int'(err_state), 1);
        for (int i = 0; i < 128; i++) begin
            rx_ok = 1; cyc("R2 tec", "R3 rec", "R4 state", "R11 rdata");
        end
        check("R4 back active", int'(err_state), 0);

        // R11: writes change nothing
        for (int i = 0; i < 20; i++) begin
            reg_wr = 1; reg_wdata = $urandom;
            cyc("R11 tec", "R11 rec", "R11 state", "R11 rdata");
        end

        // R5: 31 errors give 248, the 32nd enters bus-off
        soft_rst = 1; cyc("R8 tec", "R8 rec", "R8 state", "R8 rdata");
        rx_err = 1; cyc("R3 tec", "R3 rec", "R4 state", "R11 rdata");
        for (int i = 0; i < 31; i++) begin
            tx_err = 1; cyc("R2 tec", "R3 rec", "R4 state", "R11 rdata");
        end
        check("R5 threshold", int'(tec), 248);
        tx_err = 1; rx_err = 1;
        cyc("R5 tec", "R5 rec", "R5 state", "R5 rdata");
        check("R5 busoff", int'(err_state), 2);

        // R6: ten recessive then dominant, noisy strobes ignored
        for (int i = 0; i < 10; i++) begin
            bit_valid = 1; bit_rec = 1; tx_err = 1; rx_err = 1;
            cyc("R6 tec", "R6 rec", "R6 state", "R6 rdata");
        end
        bit_valid = 1; bit_rec = 0; cyc("R6 tec", "R6 rec", "R6 state", "R6 rdata");
        check("R6 broken run", int'(rec), 0);
        for (int i = 0; i < 11; i++) begin
            bit_valid = 1; bit_rec = 1;
            cyc("R6 tec", "R6 rec", "R6 state", "R6 rdata");
        end
        check("R6 one run", int'(rec), 1);

        // R7: random gaps and occasional dominant bits until exit
        for (int i = 0; i < 4000 && m_bo; i++) begin
            bit_valid = ($urandom % 100) < 80;
            bit_rec   = ($urandom % 100) < 99;
            tx_ok = $urandom % 2; rx_ok = $urandom % 2;
            cyc("R6 tec", "R6 rec", "R7 state", "R7 rdata");
        end
        check("R7 exited", int'(err_state), 0);
        check("R7 rec cleared", int'(rec), 0);

        // R8: soft reset during bus-off
        for (int i = 0; i < 32; i++) begin
            tx_err = 1; cyc("R2 tec", "R3 rec", "R5 state", "R11 rdata");
        end
        check("R5 busoff again", int'(err_state), 2);
        bit_valid = 1; bit_rec = 1; soft_rst = 1;
        cyc("R8 tec", "R8 rec", "R8 state", "R8 rdata");
        check("R8 active", int'(err_state), 0);

        // R9: disabled with traffic
        for (int i = 0; i < 5; i++) begin
            tx_err = 1; rx_err = 1; cyc("R2 tec", "R3 rec", "R4 state", "R11 rdata");
        end
        ctrl_en = 0;
        for (int i = 0; i < 30; i++) begin
            tx_err = $urandom % 2; rx_err = $urandom % 2;
            cyc("R9 tec", "R9 rec", "R9 state", "R9 rdata");
        end
        ctrl_en = 1;

        // R10: snoop with traffic
        for (int i = 0; i < 5; i++) begin
            tx_err = 1; rx_err = 1; cyc("R2 tec", "R3 rec", "R4 state", "R11 rdata");
        end
        snoop = 1;
        for (int i = 0; i < 30; i++) begin
            tx_err = $urandom % 2; rx_err = $urandom % 2;
            cyc("R10 tec", "R10 rec", "R10 state", "R10 rdata");
        end
        check("R10 rdata", int'(reg_rdata), 0);
        snoop = 0;

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule